// File: doc/BRIEF.md
# Auxiliary SPI master controller

A byte-wide SPI master for the save-memory port of a cartridge slot. Software configures it through a 16-bit control register and moves bytes through an 8-bit data register. A write to the data register starts a one-byte full-duplex exchange, but only when the port is in serial mode and enabled. For the length of the exchange a busy flag reads high. The length comes from a two-bit speed code. When the exchange ends, busy drops and the byte clocked in from the slave replaces the data register. If interrupts are enabled, the block raises a single-cycle interrupt pulse.

Bits go out MSB first in SPI mode 0, with the serial clock idling low. Chip select goes low when a byte starts. A hold bit can keep the slave selected across several bytes. A control write in serial mode issued while hold was off emits a one-cycle pulse that tells the slave-side logic to forget its current command.

Top module: `spi_aux_master`

## Requirements
- R1: After reset `ctrl_o` and `data_o` read 0, `cs_no` is 1, and `sclk_o`, `irq_o` and `cmd_clr_o` are 0.
- R2: The control register holds the speed code in bits 1:0, hold in bit 6, serial mode in bit 13, interrupt enable in bit 14 and port enable in bit 15. Bit 7 reads busy and cannot be written. All other bits read 0.
- R3: A data write while mode (bit 13) or enable (bit 15) is clear has no effect: busy stays 0, `data_o` keeps its value and `cs_no` stays 1.
- R4: An accepted data write sets busy on the next cycle, drives `cs_no` low, and makes `data_o` show the written byte.
- R5: Busy stays high for exactly BASE_HZ >> (19 - code) cycles. With the default BASE_HZ these are 63, 127, 255 and 511 cycles for codes 0 to 3.
- R6: At completion `data_o` takes the byte received on `miso_i`.
- R7: The written byte is shifted out MSB first on `mosi_o` with exactly 8 rising `sclk_o` edges. `mosi_o` is stable at each rising edge, and `sclk_o` is low whenever the block is not busy.
- R8: `irq_o` pulses high for one cycle in the cycle after busy falls, only if bit 14 was set. Otherwise it stays 0.
- R9: A data write while busy restarts the byte with the new data and a new duration. The interrupted byte produces no completion.
- R10: At completion `cs_no` returns high unless hold is set. With hold set, `cs_no` stays low until a control write clears hold while the block is idle.
- R11: `cmd_clr_o` pulses for one cycle after a control write that has bit 13 set, provided the stored hold bit was 0 before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control register write value |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 8 | Byte to transmit |
| ctrl_o | output | 16 | Control register readback, busy in bit 7 |
| data_o | output | 8 | Data register readback |
| irq_o | output | 1 | Completion interrupt pulse |
| cmd_clr_o | output | 1 | Pulse that clears slave command state |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Active-low chip select |

## Verification
A register write shows up in `ctrl_o`, `data_o`, `cs_no` and `cmd_clr_o` one cycle after the sampling edge. Busy falls exactly the programmed number of cycles after the accepting edge. `data_o` and `irq_o` change on that same edge. A behavioural model in the bench advances on every rising edge using only the ports and the requirements. It is compared with every output on each falling edge, so any result that arrives one cycle early or late is flagged. A slave model driven by `sclk_o` counts the edges, collects the bits shifted out and supplies the reply byte. Once each exchange is idle, its totals are checked.

// File: rtl/spi_aux_pkg.sv
package spi_aux_pkg;
  localparam int unsigned HOLD_BIT = 6;
  localparam int unsigned BUSY_BIT = 7;
  localparam int unsigned MODE_BIT = 13;
  localparam int unsigned IE_BIT   = 14;
  localparam int unsigned EN_BIT   = 15;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       mode;
    logic       hold;
    logic [1:0] code;
  } aux_cfg_t;

  function automatic int unsigned byte_cycles(int unsigned hz, int unsigned code);
    return hz >> (19 - code);
  endfunction
endpackage

// File: rtl/spi_aux_regs.sv
module spi_aux_regs
  import spi_aux_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output aux_cfg_t    cfg_o,
  output logic        cmd_clr_o
);
  aux_cfg_t cfg_q;
  logic     clr_q;
  logic     unused_bits;

  assign unused_bits = ^{wdata_i[12:7], wdata_i[5:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= we_i & wdata_i[MODE_BIT] & ~cfg_q.hold;
      if (we_i) begin
        cfg_q <= '{en:   wdata_i[EN_BIT],
                   ie:   wdata_i[IE_BIT],
                   mode: wdata_i[MODE_BIT],
                   hold: wdata_i[HOLD_BIT],
                   code: wdata_i[1:0]};
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign cmd_clr_o = clr_q;
endmodule

// File: rtl/spi_aux_timer.sv
module spi_aux_timer
  import spi_aux_pkg::*;
#(
  parameter int unsigned BASE_HZ = 33_513_982,
  parameter int unsigned CNT_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] half_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] dur_tbl [4];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < 4; g++) begin : g_dur
    assign dur_tbl[g] = CNT_W'(byte_cycles(BASE_HZ, g));
  end

  // sixteen half-periods always fit inside one byte slot
  assign half_o = dur_tbl[code_i] >> 4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= dur_tbl[code_i];
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) & ~start_i;
endmodule

// File: rtl/spi_aux_shifter.sv
module spi_aux_shifter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       wdata_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic [7:0]       rx_o
);
  localparam logic [4:0] EDGES = 5'd16;

  logic [7:0]       sh_q, rx_q;
  logic             sclk_q;
  logic [CNT_W-1:0] ph_q, half_q;
  logic [4:0]       ecnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      ph_q   <= '0;
      half_q <= '0;
      ecnt_q <= EDGES;
    end else if (start_i) begin
      sh_q   <= wdata_i;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      ph_q   <= half_i;
      half_q <= half_i;
      ecnt_q <= '0;
    end else if (ecnt_q != EDGES) begin
      if (ph_q <= CNT_W'(1)) begin
        sclk_q <= ~sclk_q;
        ph_q   <= half_q;
        ecnt_q <= ecnt_q + 5'd1;
        if (!sclk_q) rx_q <= {rx_q[6:0], miso_i};
        else         sh_q <= {sh_q[6:0], 1'b0};
      end else begin
        ph_q <= ph_q - 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_aux_master.sv
module spi_aux_master
  import spi_aux_pkg::*;
#(
  parameter int unsigned BASE_HZ = 33_513_982
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [15:0] ctrl_wdata_i,
  input  logic        data_we_i,
  input  logic [7:0]  data_wdata_i,
  output logic [15:0] ctrl_o,
  output logic [7:0]  data_o,
  output logic        irq_o,
  output logic        cmd_clr_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no
);
  localparam int unsigned MAX_DUR = byte_cycles(BASE_HZ, 3);
  localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

  aux_cfg_t         cfg;
  logic             start, busy, done;
  logic [CNT_W-1:0] half;
  logic [7:0]       rx, data_q;
  logic             irq_q, cs_n_q;

  assign start = data_we_i & cfg.mode & cfg.en;

  spi_aux_regs u_regs (
    .clk_i, .rst_ni,
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .cfg_o     (cfg),
    .cmd_clr_o (cmd_clr_o)
  );

  spi_aux_timer #(.BASE_HZ(BASE_HZ), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i (start),
    .code_i  (cfg.code),
    .half_o  (half),
    .busy_o  (busy),
    .done_o  (done)
  );

  spi_aux_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i (start),
    .wdata_i (data_wdata_i),
    .half_i  (half),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .rx_o    (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      irq_q  <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      irq_q <= done & cfg.ie;
      if (start)     data_q <= data_wdata_i;
      else if (done) data_q <= rx;
      if (start)                                            cs_n_q <= 1'b0;
      else if (done & ~cfg.hold)                            cs_n_q <= 1'b1;
      else if (ctrl_we_i & ~ctrl_wdata_i[HOLD_BIT] & ~busy) cs_n_q <= 1'b1;
    end
  end

  assign ctrl_o = {cfg.en, cfg.ie, cfg.mode, 5'b0, busy, cfg.hold, 4'b0, cfg.code};
  assign data_o = data_q;
  assign irq_o  = irq_q;
  assign cs_no  = cs_n_q;
endmodule

// File: rtl/spi_aux_chk.sv
module spi_aux_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [15:0] ctrl_wdata_i,
  input logic        data_we_i,
  input logic [15:0] ctrl_o,
  input logic        irq_o,
  input logic        cmd_clr_o,
  input logic        sclk_o,
  input logic        cs_no
);
  // R3
  ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !(ctrl_o[13] && ctrl_o[15]) && !ctrl_o[7]) |=> !ctrl_o[7]);

  // R4
  busy_selects_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] |-> !cs_no);

  // R4
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[7]) |-> $past(data_we_i && ctrl_o[13] && ctrl_o[15]));

  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[7] |-> !sclk_o);

  // R8
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!ctrl_o[7] && $past(ctrl_o[7]) && $past(ctrl_o[14])));

  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R10
  hold_keeps_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl_o[7]) && $past(ctrl_o[6])) |-> !cs_no);

  // R11
  cmd_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_clr_o |-> $past(ctrl_we_i && ctrl_wdata_i[13] && !ctrl_o[6]));
endmodule

bind spi_aux_master spi_aux_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .data_we_i    (data_we_i),
  .ctrl_o       (ctrl_o),
  .irq_o        (irq_o),
  .cmd_clr_o    (cmd_clr_o),
  .sclk_o       (sclk_o),
  .cs_no        (cs_no)
);

// File: tb/tb_spi_aux_master.sv
module tb_spi_aux_master;
  localparam int unsigned HZ = 33_513_982;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        data_we = 1'b0;
  logic [7:0]  data_wdata = '0;
  logic [15:0] ctrl_o;
  logic [7:0]  data_o;
  logic        irq_o, cmd_clr_o, sclk_o, mosi_o, miso, cs_no;

  always #10 clk = ~clk;

  spi_aux_master dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .data_we_i(data_we), .data_wdata_i(data_wdata),
    .ctrl_o(ctrl_o), .data_o(data_o), .irq_o(irq_o), .cmd_clr_o(cmd_clr_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso), .cs_no(cs_no)
  );

  int tests = 0, fails = 0, cyc = 0, irq_cnt = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic int dur(logic [1:0] c);
    return int'(HZ >> (19 - c));
  endfunction

  // slave model
  logic [7:0] slave_tx = 8'h00;
  logic [7:0] s_rx = 8'h00;
  int s_idx = 0, s_rises = 0;
  assign miso = slave_tx[7 - s_idx];
  always @(posedge sclk_o) begin
    s_rx = {s_rx[6:0], mosi_o};
    s_idx = (s_idx + 1) % 8;
    s_rises++;
  end

  // reference model
  bit m_en, m_ie, m_mode, m_hold, m_cs, m_irq, m_clr;
  logic [1:0] m_code;
  int m_cnt;
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_mode = 0; m_hold = 0; m_code = 0;
      m_cnt = 0; m_data = 0; m_cs = 1; m_irq = 0; m_clr = 0;
    end else begin : step
      bit st, was_busy;
      st = data_we && m_mode && m_en;
      was_busy = (m_cnt != 0);
      m_irq = 0;
      m_clr = 0;
      if (st) begin
        m_cnt = dur(m_code); m_data = data_wdata; m_cs = 0;
      end else if (m_cnt > 0) begin
        if (m_cnt == 1) begin
          m_data = slave_tx; m_irq = m_ie;
          if (!m_hold) m_cs = 1;
        end
        m_cnt--;
      end
      if (!st && ctrl_we && !ctrl_wdata[6] && !was_busy) m_cs = 1;
      if (ctrl_we) begin
        m_clr = ctrl_wdata[13] && !m_hold;
        m_en = ctrl_wdata[15]; m_ie = ctrl_wdata[14]; m_mode = ctrl_wdata[13];
        m_hold = ctrl_wdata[6]; m_code = ctrl_wdata[1:0];
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin : cmp
      logic [15:0] exp_ctrl;
      exp_ctrl = {m_en, m_ie, m_mode, 5'b0, m_cnt != 0, m_hold, 4'b0, m_code};
      chk(ctrl_o == exp_ctrl, "R2/R5 ctrl", ctrl_o, exp_ctrl);
      chk(data_o == m_data, "R6 data", data_o, m_data);
      chk(irq_o == m_irq, "R8 irq", irq_o, m_irq);
      chk(cs_no == m_cs, "R10 cs", cs_no, m_cs);
      chk(cmd_clr_o == m_clr, "R11 cmd_clr", cmd_clr_o, m_clr);
      chk(m_cnt != 0 || !sclk_o, "R7 sclk idle", sclk_o, 0);
      if (irq_o) irq_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R5 watchdog: actual hung expected idle");
      summary();
    end
  end

  task automatic wr_ctrl(logic [15:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic start_byte(logic [7:0] tx, logic [7:0] rx);
    @(negedge clk);
    slave_tx = rx; s_idx = 0; s_rises = 0; s_rx = 0;
    data_we = 1; data_wdata = tx;
    @(negedge clk); data_we = 0;
  endtask

  task automatic wait_idle();
    while (ctrl_o[7]) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(logic [7:0] tx, logic [7:0] rx);
    start_byte(tx, rx);
    wait_idle();
    chk(s_rx == tx, "R7 mosi byte", s_rx, tx);
    chk(s_rises == 8, "R7 edge count", s_rises, 8);
    chk(data_o == rx, "R6 received", data_o, rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(ctrl_o == 0 && data_o == 0, "R1 regs", {ctrl_o, data_o}, 0);
    chk(cs_no && !sclk_o && !irq_o && !cmd_clr_o, "R1 pins",
        {cs_no, sclk_o, irq_o, cmd_clr_o}, 4'b1000);
    rst_n = 1;
    @(negedge clk);

    // R2 readback, busy read-only; R11 pulse with hold off
    wr_ctrl(16'hFFFF);
    chk(ctrl_o == 16'hE043, "R2 layout", ctrl_o, 16'hE043);
    wr_ctrl(16'h0000);
    chk(ctrl_o == 16'h0000, "R2 clear", ctrl_o, 0);

    // R3 ignored writes
    wr_ctrl(16'h2000);
    start_byte(8'h5A, 8'h11);
    chk(!ctrl_o[7] && data_o == 0 && cs_no, "R3 mode only", {ctrl_o[7], data_o}, 0);
    wr_ctrl(16'h8000);
    start_byte(8'h5A, 8'h11);
    chk(!ctrl_o[7] && data_o == 0 && cs_no, "R3 enable only", {ctrl_o[7], data_o}, 0);

    // R4 R5 R6 R7 R8 across all codes
    for (int c = 0; c < 4; c++) begin
      int n0;
      wr_ctrl(16'hE000 | 16'(c));
      n0 = irq_cnt;
      start_byte(8'hA5 ^ 8'(c * 37), 8'h3C + 8'(c));
      chk(ctrl_o[7] && !cs_no && data_o == (8'hA5 ^ 8'(c * 37)), "R4 start",
          data_o, 8'hA5 ^ 8'(c * 37));
      wait_idle();
      chk(s_rx == (8'hA5 ^ 8'(c * 37)), "R7 mosi byte", s_rx, 8'hA5 ^ 8'(c * 37));
      chk(s_rises == 8, "R7 edge count", s_rises, 8);
      chk(data_o == 8'h3C + 8'(c), "R6 received", data_o, 8'h3C + 8'(c));
      chk(irq_cnt == n0 + 1, "R8 irq once", irq_cnt - n0, 1);
    end

    // R8 no irq when disabled
    begin
      int n0;
      wr_ctrl(16'hA000);
      n0 = irq_cnt;
      xfer(8'h81, 8'h7E);
      chk(irq_cnt == n0, "R8 irq off", irq_cnt - n0, 0);
    end

    // R9 restart while busy
    begin
      int n0;
      wr_ctrl(16'hE001);
      n0 = irq_cnt;
      start_byte(8'hF0, 8'h0F);
      repeat (40) @(negedge clk);
      xfer(8'hC3, 8'h96);
      chk(irq_cnt == n0 + 1, "R9 single completion", irq_cnt - n0, 1);
    end

    // R10 hold across bytes, R11 no pulse while hold already on
    wr_ctrl(16'hE040);
    xfer(8'h03, 8'h55);
    chk(!cs_no, "R10 held", cs_no, 0);
    wr_ctrl(16'hE040);
    chk(!cmd_clr_o, "R11 no clear under hold", cmd_clr_o, 0);
    xfer(8'h12, 8'hAA);
    chk(!cs_no, "R10 still held", cs_no, 0);
    wr_ctrl(16'hE000);
    chk(cs_no, "R10 release", cs_no, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule